// File: doc/BRIEF.md
# Coprocessor Register Write-Lock Filter

The filter sits between instruction decode and a system-control coprocessor register file. Decode presents each coprocessor access for one cycle. The access carries its direction, its selector fields (opc1, CRn, CRm, opc2) and the non-secure state bit. One cycle later the filter answers with either an allow or an undefined-instruction fault. A lock pin, driven from elsewhere on the chip, can freeze a fixed group of configuration registers against secure-state writes. The same pin also shuts the implementation-defined array window (CRn = 15) to both reads and writes.

The lock pin is asynchronous to the core. It passes through a synchronizer. It then reaches a two-state lock machine that changes only when decode signals an instruction boundary. An instruction therefore always sees one constant lock level from start to end. The machine has two states. LK_OPEN means no access is blocked. LK_SHUT means the protected set is blocked. It has three transitions, all taken at a boundary strobe: ENGAGE (LK_OPEN to LK_SHUT, when the synchronized pin is 1), RELEASE (LK_SHUT to LK_OPEN, when the synchronized pin is 0) and HOLD (no change when there is no strobe, or when the pin level already matches the state).

Top module: `cpreg_lock_gate`

## Requirements
- R1: While reset is asserted and after it is released, acc_fault and acc_allow are 0 and the lock machine is in LK_OPEN. The first access after reset is allowed.
- R2: An access presented with acc_valid=1 at a clock edge is answered at that edge. After that edge exactly one of acc_fault and acc_allow is 1, for one cycle. When acc_valid=0 both are 0.
- R3: In LK_SHUT with acc_nonsecure=0, a write (acc_write=1) with opc1=0 to any of these nine CRn/CRm/opc2 triples faults: 1/0/0, 2/0/0, 2/0/2, 3/0/0, 10/2/0, 10/2/1, 12/0/0, 12/0/1, 13/0/0.
- R4: In LK_SHUT with acc_nonsecure=0, every access with opc1=0 and CRn=15 faults, for any CRm and opc2, both for reads (acc_write=0) and for writes.
- R5: When acc_nonsecure=1, or the machine is in LK_OPEN, every access is allowed, whatever its encoding.
- R6: In LK_SHUT with acc_nonsecure=0, the following accesses are allowed: every access with opc1 other than 0, reads outside CRn=15, and writes to triples outside the R3 list with CRn other than 15.
- R7: The lock pin goes through a chain of SYNC_STAGES flops (2 by default). The machine loads the pin level that the chain delivers only at an edge where insn_boundary=1. Pin changes between strobes have no effect. A strobe one edge after a pin change still loads the old level.
- R8: When acc_valid and insn_boundary are 1 at the same edge, the access is judged against the lock state in force before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pin | input | 1 | Asynchronous lock request from the chip |
| insn_boundary | input | 1 | Instruction-boundary strobe from decode |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_opc1 | input | 3 | First opcode selector |
| acc_crn | input | 4 | Primary register selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_opc2 | input | 3 | Second opcode selector |
| acc_nonsecure | input | 1 | 1 = access made in non-secure state |
| acc_fault | output | 1 | Raise undefined-instruction exception |
| acc_allow | output | 1 | Access may proceed |

## Verification
The assertions check four things on every cycle. The response is one-hot, and it is silent when there is no access. Non-secure accesses are always allowed. A locked, secure access to the write list or to the CRn=15 window always faults. The lock state moves only on a boundary strobe, and then to the synchronized pin level. Some behaviours only the bench scenarios can show. These are the full decision over every selector, direction and lock/security pairing, and the exact cycle at which a pin change becomes visible through the synchronizer. The bench also shows the strobe-and-access collision and that pin toggles inside an instruction are ignored.

// File: rtl/cplock_pkg.sv
package cplock_pkg;

    localparam int OPC1_W = 3;
    localparam int CRN_W  = 4;
    localparam int CRM_W  = 4;
    localparam int OPC2_W = 3;
    localparam int KEY_W  = CRN_W + CRM_W + OPC2_W;

    localparam logic [CRN_W-1:0] ARRAY_CRN = 4'd15;

    localparam int WLIST_N = 9;

    typedef logic [KEY_W-1:0] sel_key_t;

    function automatic sel_key_t mk_key(input logic [CRN_W-1:0] n,
                                        input logic [CRM_W-1:0] m,
                                        input logic [OPC2_W-1:0] o);
        return {n, m, o};
    endfunction

    localparam sel_key_t WLIST [WLIST_N] = '{
        {4'd1,  4'd0, 3'd0},
        {4'd2,  4'd0, 3'd0},
        {4'd2,  4'd0, 3'd2},
        {4'd3,  4'd0, 3'd0},
        {4'd10, 4'd2, 3'd0},
        {4'd10, 4'd2, 3'd1},
        {4'd12, 4'd0, 3'd0},
        {4'd12, 4'd0, 3'd1},
        {4'd13, 4'd0, 3'd0}
    };

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_t;

endpackage

// File: rtl/cplock_sync.sv
module cplock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[TOP];

endmodule

// File: rtl/cplock_boundary_fsm.sv
module cplock_boundary_fsm
    import cplock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_sync,
    input  logic boundary,
    output logic lock_eff
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (boundary && lock_sync)  state_d = LK_SHUT;
            LK_SHUT: if (boundary && !lock_sync) state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN: lock_eff = 1'b0;
            LK_SHUT: lock_eff = 1'b1;
        endcase
    end

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(lock_eff));

    a_r7_load_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (lock_eff == $past(lock_sync)));

endmodule

// File: rtl/cplock_classify.sv
module cplock_classify
    import cplock_pkg::*;
(
    input  logic [OPC1_W-1:0] opc1,
    input  logic [CRN_W-1:0]  crn,
    input  logic [CRM_W-1:0]  crm,
    input  logic [OPC2_W-1:0] opc2,
    output logic              hit_wlist,
    output logic              hit_array
);
    sel_key_t             key;
    logic [WLIST_N-1:0]   match;
    logic                 base_space;

    assign key        = mk_key(crn, crm, opc2);
    assign base_space = (opc1 == '0);

    generate
        for (genvar i = 0; i < WLIST_N; i++) begin : g_wl
            assign match[i] = (key == WLIST[i]);
        end
    endgenerate

    assign hit_wlist = base_space && (|match);
    assign hit_array = base_space && (crn == ARRAY_CRN);

    always_comb begin
        a_r6_disjoint: assert (!(hit_wlist && hit_array));
    end

endmodule

// File: rtl/cpreg_lock_gate.sv
module cpreg_lock_gate
    import cplock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_pin,
    input  logic              insn_boundary,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OPC1_W-1:0] acc_opc1,
    input  logic [CRN_W-1:0]  acc_crn,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OPC2_W-1:0] acc_opc2,
    input  logic              acc_nonsecure,
    output logic              acc_fault,
    output logic              acc_allow
);
    logic lock_sync;
    logic lock_eff;
    logic hit_wlist;
    logic hit_array;
    logic blocked;

    cplock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_pin),
        .sync_out (lock_sync)
    );

    cplock_boundary_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_sync (lock_sync),
        .boundary  (insn_boundary),
        .lock_eff  (lock_eff)
    );

    cplock_classify u_cls (
        .opc1      (acc_opc1),
        .crn       (acc_crn),
        .crm       (acc_crm),
        .opc2      (acc_opc2),
        .hit_wlist (hit_wlist),
        .hit_array (hit_array)
    );

    assign blocked = lock_eff && !acc_nonsecure &&
                     ((acc_write && hit_wlist) || hit_array);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_fault <= 1'b0;
            acc_allow <= 1'b0;
        end else begin
            acc_fault <= acc_valid && blocked;
            acc_allow <= acc_valid && !blocked;
        end
    end

    a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_fault ^ acc_allow));

    a_r2_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!acc_fault && !acc_allow));

    a_r5_nonsecure_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_nonsecure) |=> acc_allow);

    a_r3_wlist_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && lock_eff && !acc_nonsecure && hit_wlist) |=> acc_fault);

    a_r4_array_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && lock_eff && !acc_nonsecure && hit_array) |=> acc_fault);

endmodule

// File: tb/cpreg_lock_gate_bench.sv
module cpreg_lock_gate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_pin = 1'b0;
    logic       insn_boundary = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [2:0] acc_opc1 = '0;
    logic [3:0] acc_crn = '0;
    logic [3:0] acc_crm = '0;
    logic [2:0] acc_opc2 = '0;
    logic       acc_nonsecure = 1'b0;
    logic       acc_fault;
    logic       acc_allow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cpreg_lock_gate u_cpreg_lock_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_pin      (lock_pin),
        .insn_boundary (insn_boundary),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_opc1      (acc_opc1),
        .acc_crn       (acc_crn),
        .acc_crm       (acc_crm),
        .acc_opc2      (acc_opc2),
        .acc_nonsecure (acc_nonsecure),
        .acc_fault     (acc_fault),
        .acc_allow     (acc_allow)
    );

    function automatic bit in_wlist(input int n, input int m, input int o);
        return (n == 1  && m == 0 && o == 0) || (n == 2  && m == 0 && o == 0) ||
               (n == 2  && m == 0 && o == 2) || (n == 3  && m == 0 && o == 0) ||
               (n == 10 && m == 2 && o == 0) || (n == 10 && m == 2 && o == 1) ||
               (n == 12 && m == 0 && o == 0) || (n == 12 && m == 0 && o == 1) ||
               (n == 13 && m == 0 && o == 0);
    endfunction

    function automatic bit want_fault(input bit lk, input bit ns, input bit wr,
                                      input int o1, input int n, input int m, input int o2);
        if (!lk || ns || o1 != 0) return 1'b0;
        if (n == 15) return 1'b1;
        if (!wr) return 1'b0;
        return in_wlist(n, m, o2);
    endfunction

    task automatic check(input string req, input bit got_f, input bit got_a,
                         input bit exp_f, input bit exp_a);
        n_checks++;
        if (got_f !== exp_f || got_a !== exp_a) begin
            n_fail++;
            $display("FAIL %s: fault/allow actual %b/%b expected %b/%b",
                     req, got_f, got_a, exp_f, exp_a);
        end
    endtask

    // Drive one access on a negedge; outputs register at the next posedge and are read at the following negedge.
    task automatic access(input string req, input bit wr, input bit ns, input int o1,
                          input int n, input int m, input int o2, input bit exp_f);
        acc_valid     = 1'b1;
        acc_write     = wr;
        acc_nonsecure = ns;
        acc_opc1      = 3'(o1);
        acc_crn       = 4'(n);
        acc_crm       = 4'(m);
        acc_opc2      = 3'(o2);
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, acc_fault, acc_allow, exp_f, !exp_f);
    endtask

    task automatic strobe();
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    task automatic set_lock(input bit v);
        lock_pin = v;
        repeat (3) @(negedge clk);
        strobe();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 during reset", acc_fault, acc_allow, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", acc_fault, acc_allow, 1'b0, 1'b0);
        access("R1 first access", 1'b1, 1'b0, 0, 15, 0, 0, 1'b0);
        @(negedge clk);
        check("R2 idle silent", acc_fault, acc_allow, 1'b0, 1'b0);
    endtask

    task automatic t_sweep(input bit lk, input bit ns);
        string tag;
        set_lock(lk);
        for (int wr = 0; wr < 2; wr++)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    for (int o2 = 0; o2 < 8; o2++) begin
                        bit ef;
                        ef = want_fault(lk, ns, wr[0], 0, n, m, o2);
                        if (!lk || ns)      tag = "R5 sweep";
                        else if (n == 15)   tag = "R4 sweep";
                        else if (ef)        tag = "R3 sweep";
                        else                tag = "R6 sweep";
                        access(tag, wr[0], ns, 0, n, m, o2, ef);
                    end
        for (int o1 = 1; o1 < 8; o1++)
            for (int wr = 0; wr < 2; wr++) begin
                access("R6 opc1 nonzero array", wr[0], ns, o1, 15, 3, 5, 1'b0);
                access("R6 opc1 nonzero list",  wr[0], ns, o1, 1, 0, 0, 1'b0);
            end
    endtask

    task automatic t_mid_toggle();
        set_lock(1'b0);
        lock_pin = 1'b1;
        strobe();
        access("R7 strobe too early after pin rise", 1'b1, 1'b0, 0, 1, 0, 0, 1'b0);
        repeat (6) @(negedge clk);
        access("R7 pin high without strobe", 1'b1, 1'b0, 0, 3, 0, 0, 1'b0);
        strobe();
        access("R7 lock after strobe", 1'b1, 1'b0, 0, 3, 0, 0, 1'b1);
        lock_pin = 1'b0;
        repeat (5) @(negedge clk);
        access("R7 pin low without strobe", 1'b0, 1'b0, 0, 15, 7, 7, 1'b1);
        lock_pin = 1'b1;
        repeat (2) @(negedge clk);
        lock_pin = 1'b0;
        repeat (4) @(negedge clk);
        access("R7 glitch inside instruction", 1'b1, 1'b0, 0, 12, 0, 1, 1'b1);
    endtask

    task automatic t_collide();
        insn_boundary = 1'b1;
        access("R8 access with releasing strobe", 1'b1, 1'b0, 0, 13, 0, 0, 1'b1);
        insn_boundary = 1'b0;
        access("R8 access after release", 1'b1, 1'b0, 0, 13, 0, 0, 1'b0);
        lock_pin = 1'b1;
        repeat (3) @(negedge clk);
        insn_boundary = 1'b1;
        access("R8 access with engaging strobe", 1'b0, 1'b0, 0, 15, 0, 0, 1'b0);
        insn_boundary = 1'b0;
        access("R8 access after engage", 1'b0, 1'b0, 0, 15, 0, 0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep(1'b0, 1'b0);
        t_sweep(1'b0, 1'b1);
        t_sweep(1'b1, 1'b1);
        t_sweep(1'b1, 1'b0);
        t_mid_toggle();
        t_collide();
        finish_run();
    end

endmodule